// File: doc/BRIEF.md
# Preloadable Performance Counter Bank

The block holds a bank of 64-bit event counters for a graphics pipeline and makes them available over a simple 32-bit register bus. Each regular counter has its own select register. That register picks one of the event input lines, and the counter adds one on every clock where that line is high and counting is enabled. One global run bit starts all regular counters together and freezes them together. While they are frozen, software can read the low and high words of any counter and get a consistent 64-bit value.

Software can preset any regular counter. It first writes a 64-bit value through a low-word register and a high-word register. It then writes a mask to one of two load-command registers. The counter number divided by 32 chooses which command register to use, and the remainder chooses the bit inside it. Two fixed power counters sit beside the regular bank. Each has its own run bit in a separate power-control register, and they cannot be preset.

The bus is a single-cycle write port with a combinational read port. A write is taken on the clock edge where the write enable is high. The read data follows the address within the same cycle.

Top module: `perfbank_top`

## Requirements
- R1: Regular counter i is read as two words: the low 32 bits at word address 0x40+2i and the high 32 bits at 0x41+2i. Power counter j has its low word at 0xA0+2j and its high word at 0xA1+2j.
- R2: Bit 0 of the run register at address 0x00 enables the regular counters. While it is set, a counter adds exactly one on each clock edge where its selected event input is high. While it is clear, every regular counter holds its value and ignores its event input.
- R3: The select register of counter i is at address 0x10+i. It holds a 5-bit event index that reads back. Writing it clears that counter to zero on the same edge.
- R4: The load value is written as a low word at 0x02 and a high word at 0x03, and both words read back.
- R5: Bit k of the command register at 0x04 loads counter k, and bit k of the command register at 0x05 loads counter 32+k. The load takes effect on the write edge, wins over an increment on that edge, and leaves unselected counters untouched. Bits that name no counter have no effect.
- R6: The command registers self-clear and always read as zero.
- R7: In the power-control register at 0x01, bit 16 runs power counter 0 and bit 17 runs power counter 1. A power counter is frozen while its bit is clear. The power counters do not depend on the global run bit, and load commands never change them.
- R8: Every counter wraps modulo 2^64.
- R9: A read has no side effects, so repeated reads return the same value. Addresses that are not mapped read as zero.
- R10: Reset clears all counters, select registers, control registers and load-value registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 8 | Word address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_i | input | 32 | Event lines that the regular counters select from |
| pwr_evt_i | input | 2 | Event lines of the two power counters |

## Verification
The hardest case to reach from the ports is an edge where a counter is loaded while its selected event is high and the bank is running. The load has to win over the increment on that one edge. The bench holds the event high across the command write and drops it on the falling edge that follows. The result has to equal the load value exactly, not the load value plus one. The wrap case is reached the same way: the bench presets a counter to two below 2^64, runs it for three events, and checks for a result of one.

// File: rtl/perfbank_pkg.sv
package perfbank_pkg;
    // word addresses of the control registers
    localparam int ADR_RUN    = 'h00;
    localparam int ADR_PWRCTL = 'h01;
    localparam int ADR_LDLO   = 'h02;
    localparam int ADR_LDHI   = 'h03;
    localparam int ADR_CMD0   = 'h04;
    localparam int ADR_CMD1   = 'h05;
    // bases of the repeated windows
    localparam int SEL_BASE   = 'h10;
    localparam int CNT_BASE   = 'h40;
    localparam int PWR_BASE   = 'hA0;
    // first run bit of the power counters in the power-control word
    localparam int PWR_RUN_LSB = 16;
endpackage

// File: rtl/perfbank_counter.sv
module perfbank_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    // a load wins over a clear, and a clear wins over an increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (ld_i)
            cnt_o <= ld_val_i;
        else if (clr_i)
            cnt_o <= '0;
        else if (inc_i)
            cnt_o <= cnt_o + CNT_W'(1);
    end
endmodule

// File: rtl/perfbank_decode.sv
module perfbank_decode
    import perfbank_pkg::*;
#(
    parameter int NUM_CNT = 43,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic               run_we,
    output logic               pwrctl_we,
    output logic               ldlo_we,
    output logic               ldhi_we,
    output logic [NUM_CNT-1:0] sel_we,
    output logic [NUM_CNT-1:0] ld_vec
);
    int adr;
    assign adr = int'(bus_addr);

    assign run_we    = bus_we && (adr == ADR_RUN);
    assign pwrctl_we = bus_we && (adr == ADR_PWRCTL);
    assign ldlo_we   = bus_we && (adr == ADR_LDLO);
    assign ldhi_we   = bus_we && (adr == ADR_LDHI);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        // the command register is chosen by i / DW, the bit by i % DW
        localparam int CMD_ADR = ADR_CMD0 + (i / DW);
        localparam int CMD_BIT = i % DW;
        assign sel_we[i] = bus_we && (adr == SEL_BASE + i);
        assign ld_vec[i] = bus_we && (adr == CMD_ADR) && bus_wdata[CMD_BIT];
    end
endmodule

// File: rtl/perfbank_rdmux.sv
module perfbank_rdmux
    import perfbank_pkg::*;
#(
    parameter int NUM_CNT = 43,
    parameter int NUM_PWR = 2,
    parameter int SEL_W   = 5,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic [AW-1:0]                   addr,
    input  logic                            run_q,
    input  logic [DW-1:0]                   pwr_ctl,
    input  logic [DW-1:0]                   ld_lo,
    input  logic [DW-1:0]                   ld_hi,
    input  logic [NUM_CNT-1:0][SEL_W-1:0]   sel_q,
    input  logic [NUM_CNT-1:0][2*DW-1:0]    cnt_all,
    input  logic [NUM_PWR-1:0][2*DW-1:0]    pwr_all,
    output logic [DW-1:0]                   rdata
);
    always_comb begin
        int a;
        a = int'(addr);
        rdata = '0;
        if (a == ADR_RUN)    rdata[0] = run_q;
        if (a == ADR_PWRCTL) rdata = pwr_ctl;
        if (a == ADR_LDLO)   rdata = ld_lo;
        if (a == ADR_LDHI)   rdata = ld_hi;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (a == SEL_BASE + i)         rdata[SEL_W-1:0] = sel_q[i];
            if (a == CNT_BASE + 2*i)       rdata = cnt_all[i][DW-1:0];
            if (a == CNT_BASE + 2*i + 1)   rdata = cnt_all[i][2*DW-1:DW];
        end
        for (int j = 0; j < NUM_PWR; j++) begin
            if (a == PWR_BASE + 2*j)       rdata = pwr_all[j][DW-1:0];
            if (a == PWR_BASE + 2*j + 1)   rdata = pwr_all[j][2*DW-1:DW];
        end
    end
endmodule

// File: rtl/perfbank_top.sv
module perfbank_top
    import perfbank_pkg::*;
#(
    parameter int NUM_CNT = 43,
    parameter int NUM_PWR = 2,
    parameter int NUM_EVT = 32,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_PWR-1:0] pwr_evt_i
);
    localparam int CNT_W = 2 * DW;
    localparam int SEL_W = $clog2(NUM_EVT);

    logic                          run_we, pwrctl_we, ldlo_we, ldhi_we;
    logic [NUM_CNT-1:0]            sel_we, ld_vec, evt_hit;
    logic                          run_q;
    logic [DW-1:0]                 pwr_ctl, ld_lo, ld_hi;
    logic [CNT_W-1:0]              ld_val;
    logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_PWR-1:0][CNT_W-1:0] pwr_all;
    logic [NUM_PWR-1:0]            pwr_inc;

    perfbank_decode #(.NUM_CNT(NUM_CNT), .AW(AW), .DW(DW)) u_dec (
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .run_we(run_we), .pwrctl_we(pwrctl_we), .ldlo_we(ldlo_we),
        .ldhi_we(ldhi_we), .sel_we(sel_we), .ld_vec(ld_vec)
    );

    // control register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pwr_ctl <= '0;
            ld_lo   <= '0;
            ld_hi   <= '0;
        end else begin
            if (run_we)    run_q   <= bus_wdata[0];
            if (pwrctl_we) pwr_ctl <= bus_wdata;
            if (ldlo_we)   ld_lo   <= bus_wdata;
            if (ldhi_we)   ld_hi   <= bus_wdata;
        end
    end

    assign ld_val = {ld_hi, ld_lo};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[i] <= '0;
            else if (sel_we[i])
                sel_q[i] <= bus_wdata[SEL_W-1:0];
        end
        assign evt_hit[i] = run_q && evt_i[sel_q[i]];
        perfbank_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr_i(sel_we[i]), .ld_i(ld_vec[i]),
            .ld_val_i(ld_val), .inc_i(evt_hit[i]), .cnt_o(cnt_all[i])
        );
    end

    for (genvar j = 0; j < NUM_PWR; j++) begin : g_pwr
        assign pwr_inc[j] = pwr_ctl[PWR_RUN_LSB + j] && pwr_evt_i[j];
        perfbank_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .ld_i(1'b0),
            .ld_val_i('0), .inc_i(pwr_inc[j]), .cnt_o(pwr_all[j])
        );
    end

    perfbank_rdmux #(.NUM_CNT(NUM_CNT), .NUM_PWR(NUM_PWR), .SEL_W(SEL_W),
                     .AW(AW), .DW(DW)) u_rd (
        .addr(bus_addr), .run_q(run_q), .pwr_ctl(pwr_ctl), .ld_lo(ld_lo),
        .ld_hi(ld_hi), .sel_q(sel_q), .cnt_all(cnt_all), .pwr_all(pwr_all),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/perfbank_chk.sv
module perfbank_chk
    import perfbank_pkg::*;
#(
    parameter int NUM_CNT = 43,
    parameter int NUM_PWR = 2,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            run_q,
    input logic [NUM_CNT-1:0]              ld_vec,
    input logic [NUM_CNT-1:0]              sel_we,
    input logic [NUM_CNT-1:0]              evt_hit,
    input logic [NUM_CNT-1:0][2*DW-1:0]    cnt_all,
    input logic [NUM_PWR-1:0][2*DW-1:0]    pwr_all,
    input logic [DW-1:0]                   pwr_ctl,
    input logic [2*DW-1:0]                 ld_val,
    input logic [AW-1:0]                   bus_addr,
    input logic [DW-1:0]                   bus_rdata
);
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_a
        AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q && !ld_vec[i] && !sel_we[i]) |=> $stable(cnt_all[i])); // R2
        AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_vec[i] && !sel_we[i]) |=>
            (cnt_all[i] == $past(cnt_all[i]) + (2*DW)'($past(evt_hit[i])))); // R8
        AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            ld_vec[i] |=> (cnt_all[i] == $past(ld_val))); // R5
        AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_we[i] && !ld_vec[i]) |=> (cnt_all[i] == '0)); // R3
    end
    for (genvar j = 0; j < NUM_PWR; j++) begin : g_p
        AST_PWR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_ctl[PWR_RUN_LSB + j] |=> $stable(pwr_all[j])); // R7
    end
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == ADR_CMD0 || int'(bus_addr) == ADR_CMD1) |-> (bus_rdata == '0)); // R6
endmodule

bind perfbank_top perfbank_chk #(
    .NUM_CNT(NUM_CNT), .NUM_PWR(NUM_PWR), .AW(AW), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .ld_vec(ld_vec), .sel_we(sel_we),
    .evt_hit(evt_hit), .cnt_all(cnt_all), .pwr_all(pwr_all), .pwr_ctl(pwr_ctl),
    .ld_val(ld_val), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sim_perfbank_top.sv
module sim_perfbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_i = '0;
    logic [1:0]  pwr_evt_i = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    perfbank_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .pwr_evt_i(pwr_evt_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 8'(a);
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(input int i, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd('h40 + 2*i, lo);
        rd('h41 + 2*i, hi);
        v = {hi, lo};
    endtask

    task automatic rd_pwr(input int j, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd('hA0 + 2*j, lo);
        rd('hA1 + 2*j, hi);
        v = {hi, lo};
    endtask

    task automatic pulse_evt(input int idx, input int n);
        evt_i[idx] = 1'b1;
        repeat (n) @(negedge clk);
        evt_i[idx] = 1'b0;
    endtask

    task automatic pulse_pwr(input logic [1:0] m, input int n);
        pwr_evt_i = m;
        repeat (n) @(negedge clk);
        pwr_evt_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic [63:0] v;
        rd('h00, d);   chk("R10 run reg", 64'(d), 0);
        rd_cnt(5, v);  chk("R10 counter 5", v, 0);
        rd('h13, d);   chk("R10 select 3", 64'(d), 0);
        rd_pwr(0, v);  chk("R10 power 0", v, 0);
    endtask

    task automatic t_select_clear;
        logic [31:0] d; logic [63:0] v;
        wr('h02, 55); wr('h03, 0); wr('h04, 32'h8);
        rd_cnt(3, v);  chk("R5 preload counter 3", v, 55);
        wr('h13, 7);
        rd_cnt(3, v);  chk("R3 select write clears", v, 0);
        rd('h13, d);   chk("R3 select readback", 64'(d), 7);
    endtask

    task automatic t_run_freeze;
        logic [63:0] v, v2;
        pulse_evt(7, 5);
        rd_cnt(3, v);  chk("R2 frozen ignores events", v, 0);
        wr('h00, 1);
        pulse_evt(7, 6);
        rd_cnt(3, v);  chk("R2 counts while running", v, 6);
        rd_cnt(3, v2); chk("R9 repeat read same", v2, v);
        wr('h00, 0);
        pulse_evt(7, 4);
        rd_cnt(3, v);  chk("R2 freeze holds", v, 6);
    endtask

    task automatic t_load_override;
        logic [31:0] d; logic [63:0] v;
        wr('h00, 1); wr('h02, 100); wr('h03, 0);
        evt_i[7] = 1'b1;
        wr('h04, 32'h8);
        evt_i[7] = 1'b0;
        wr('h00, 0);
        rd_cnt(3, v);  chk("R5 load beats increment", v, 100);
        rd('h04, d);   chk("R6 cmd0 reads zero", 64'(d), 0);
    endtask

    task automatic t_wrap;
        logic [31:0] d; logic [63:0] v;
        wr('h02, 32'hFFFF_FFFE); wr('h03, 32'hFFFF_FFFF);
        rd('h02, d);   chk("R4 load low readback", 64'(d), 64'hFFFF_FFFE);
        rd('h03, d);   chk("R4 load high readback", 64'(d), 64'hFFFF_FFFF);
        wr('h10 + 42, 31);
        wr('h05, 32'h400);
        rd('h40 + 84, d); chk("R1 low word counter 42", 64'(d), 64'hFFFF_FFFE);
        rd('h41 + 84, d); chk("R1 high word counter 42", 64'(d), 64'hFFFF_FFFF);
        wr('h00, 1);
        pulse_evt(31, 3);
        wr('h00, 0);
        rd_cnt(42, v); chk("R8 wraps to one", v, 1);
    endtask

    task automatic t_cmd_bits;
        logic [31:0] d; logic [63:0] v;
        wr('h02, 5); wr('h03, 0);
        wr('h05, 32'hFFFF_F800);
        rd_cnt(42, v); chk("R5 unused cmd bits no effect c42", v, 1);
        rd_cnt(32, v); chk("R5 unused cmd bits no effect c32", v, 0);
        wr('h05, 32'h1);
        rd_cnt(32, v); chk("R5 cmd1 bit0 loads counter 32", v, 5);
        rd_cnt(42, v); chk("R5 other counter untouched", v, 1);
        rd('h05, d);   chk("R6 cmd1 reads zero", 64'(d), 0);
        rd('hFF, d);   chk("R9 unmapped reads zero", 64'(d), 0);
    endtask

    task automatic t_power;
        logic [31:0] d; logic [63:0] v;
        pulse_pwr(2'b11, 4);
        rd_pwr(0, v);  chk("R7 power 0 frozen", v, 0);
        rd_pwr(1, v);  chk("R7 power 1 frozen", v, 0);
        wr('h01, 32'h0001_0000);
        pulse_pwr(2'b11, 4);
        rd_pwr(0, v);  chk("R7 power 0 runs without global", v, 4);
        rd_pwr(1, v);  chk("R7 power 1 own freeze", v, 0);
        wr('h01, 32'h0003_0000);
        pulse_pwr(2'b11, 2);
        wr('h01, 0);
        rd_pwr(0, v);  chk("R7 power 0 total", v, 6);
        rd_pwr(1, v);  chk("R7 power 1 total", v, 2);
        wr('h04, 32'hFFFF_FFFF); wr('h05, 32'hFFFF_FFFF);
        rd_pwr(0, v);  chk("R7 loads never touch power", v, 6);
        rd('h01, d);   chk("R7 power ctl readback", 64'(d), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select_clear();
        t_run_freeze();
        t_load_override();
        t_wrap();
        t_cmd_bits();
        t_power();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule